// File: doc/BRIEF.md
# Dual Down-Counting Timer Unit

A register-mapped peripheral holding two independent down-counters. Each counter owns a reload value and a control word. The control word carries a two-bit operation code, which can load, hold or run the counter, and a three-bit source code. The source code picks how often a tick enable fires, and every tick rate is derived from the single fast reference clock. A running counter steps down once per tick. When it is at zero on a tick it reloads and raises its bit in a shared raw status register.

A mask register selects which status bits drive the single interrupt output. Software clears status bits by writing ones to an acknowledge register. A free-running time register counts reference cycles. The bus is a simple single-cycle 32-bit bus with combinational read data. A size code on each access marks it as byte, halfword or word, and only word accesses act.

Each channel has a two-state controller with the states HALT and RUN. The transitions are:
- HALT to HALT on a load write, which also copies the reload value, or on a hold write.
- HALT to RUN on a run write.
- RUN to HALT on a load or hold write.
- RUN to RUN on a run write, which restarts the tick divider.
- An illegal-code write changes no state.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset both channels are halted, both counts are zero, both control words read 0, status and mask read 0 and `irq` is low.
- R2: A word write of operation code 0 (bits [1:0]) to a control word copies that channel's reload value into its count and leaves the channel halted.
- R3: With operation code 2 the count drops by one on each tick. On a tick with the count at zero it reloads, so the period is reload+1 ticks. Reaching zero sets status bit 0 for channel 0 and status bit 1 for channel 1.
- R4: Control bits [4:2] form the source code c. Ticks come every (8-c)*TICK_SCALE reference cycles, and the first tick arrives that many cycles after the run write. Code 7 is the fastest.
- R5: Operation code 1 halts the channel and freezes its count.
- R6: A control write with operation code 3 changes neither the stored control word, the channel state nor its count.
- R7: `irq` is high exactly when (status AND mask) is nonzero. It follows a mask write in the cycle after that write.
- R8: Writing a 1 to bit n of the acknowledge register at 0x4C clears status bit n, and a 0 leaves the bit set. A terminal count in the same cycle as the acknowledge keeps its bit set.
- R9: Only accesses with size code 2 act. Other writes change nothing, and other reads return 0.
- R10: The register map is:

  | Offset | Register |
  |---|---|
  | 0x00 | channel 0 reload |
  | 0x04 | channel 0 control (bits [4:0]) |
  | 0x08 | channel 0 count |
  | 0x10 | channel 1 reload |
  | 0x14 | channel 1 count |
  | 0x18 | channel 1 control |
  | 0x38 | time |
  | 0x48 | mask |
  | 0x50 | status |

  Reload and control read back the last accepted value. The acknowledge register and unmapped offsets read 0.
- R11: The time register increases by one every reference cycle and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast reference clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_size | input | 2 | access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | byte offset |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | read data, combinational |
| irq | output | 1 | masked interrupt |

## Verification
The checker assumes the bus never asserts a read and a write in the same cycle. It also assumes that status and interrupt changes trace back only to bus writes or terminal counts, because no other input exists. The bench keeps to this by driving one access per cycle from tasks that change inputs on the falling edge. It lets a channel run only after loading it, and it halts every channel before acknowledging status for the next case. The sweep covers both channels, source codes 5 to 7 and reload values 0 to 3. Expected counts and status come from tick arithmetic in the bench.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
package dtu_pkg;
    localparam int NUM_CH = 2;
    localparam int SRC_W  = 3;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_HOLD    = 2'd1,
        OP_RUN     = 2'd2,
        OP_ILLEGAL = 2'd3
    } op_e;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        op_e              op;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ACC_WORD = 2'd2;

    localparam int OFS_TIME = 'h38;
    localparam int OFS_MASK = 'h48;
    localparam int OFS_ACK  = 'h4C;
    localparam int OFS_STAT = 'h50;

    function automatic int reload_ofs(int ch);
        return (ch == 0) ? 'h00 : 'h10;
    endfunction

    function automatic int ctrl_ofs(int ch);
        return (ch == 0) ? 'h04 : 'h18;
    endfunction

    function automatic int count_ofs(int ch);
        return (ch == 0) ? 'h08 : 'h14;
    endfunction
endpackage

// File: rtl/dtu_prescale.sv
`timescale 1ns/1ps
module dtu_prescale
    import dtu_pkg::*;
#(
    parameter int PS_W       = 8,
    parameter int TICK_SCALE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic [SRC_W-1:0] src,
    output logic             tick
);
    logic [PS_W-1:0] div_cnt;
    logic [PS_W-1:0] limit;

    // divide ratio falls as the source code rises; code 7 is the fastest
    always_comb begin
        limit = PS_W'((8 - int'(src)) * TICK_SCALE - 1);
    end

    always_comb begin
        tick = enable && !restart && (div_cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (restart || !enable) begin
            div_cnt <= '0;
        end else if (div_cnt == limit) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dtu_chan.sv
`timescale 1ns/1ps
module dtu_chan
    import dtu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  op_e              op_in,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             tc
);
    ch_state_e        state_q;
    ch_state_e        state_nx;
    logic [CNT_W-1:0] count_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_HALT;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: load and hold halt, run starts, illegal keeps state
    always_comb begin
        state_nx = state_q;
        if (ctrl_we) begin
            unique case (op_in)
                OP_LOAD:    state_nx = CH_HALT;
                OP_HOLD:    state_nx = CH_HALT;
                OP_RUN:     state_nx = CH_RUN;
                OP_ILLEGAL: state_nx = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (ctrl_we && op_in == OP_LOAD) begin
            count_q <= reload;
        end else if (state_q == CH_RUN && tick) begin
            count_q <= (count_q == '0) ? reload : count_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        running = (state_q == CH_RUN);
        tc      = (state_q == CH_RUN) && tick && (count_q == '0);
        count   = count_q;
    end
endmodule

// File: rtl/dtu_intc.sv
`timescale 1ns/1ps
module dtu_intc #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc,
    input  logic           mask_we,
    input  logic           ack_we,
    input  logic [NCH-1:0] wbits,
    output logic [NCH-1:0] status,
    output logic [NCH-1:0] mask,
    output logic           irq
);
    logic [NCH-1:0] status_q;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] clr;

    always_comb begin
        clr = ack_we ? wbits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            // a terminal count beats an acknowledge in the same cycle
            status_q <= (status_q & ~clr) | tc;
            if (mask_we) begin
                mask_q <= wbits;
            end
        end
    end

    always_comb begin
        status = status_q;
        mask   = mask_q;
        irq    = |(status_q & mask_q);
    end
endmodule

// File: rtl/dual_timer_unit.sv
`timescale 1ns/1ps
module dual_timer_unit
    import dtu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TIME_W     = 32,
    parameter int PS_W       = 8,
    parameter int TICK_SCALE = 1,
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int ADDR_INT = 32;

    logic              word_acc;
    logic              wr_ok;
    logic              rd_ok;
    logic [ADDR_INT-1:0] addr_i;

    logic [CNT_W-1:0]  reload_q [NUM_CH];
    ctrl_t             ctrl_q   [NUM_CH];
    logic [CNT_W-1:0]  cnt_arr  [NUM_CH];
    logic [NUM_CH-1:0] ctrl_we;
    logic [NUM_CH-1:0] tick_vec;
    logic [NUM_CH-1:0] run_vec;
    logic [NUM_CH-1:0] tc_vec;
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] mask_q;
    logic              mask_we;
    logic              ack_we;
    logic [TIME_W-1:0] time_q;
    ctrl_t             wctrl;

    always_comb begin
        word_acc = (bus_size == ACC_WORD);
        wr_ok    = bus_wr && word_acc;
        rd_ok    = bus_rd && word_acc;
        addr_i   = ADDR_INT'(bus_addr);
        wctrl    = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        mask_we  = wr_ok && (addr_i == OFS_MASK);
        ack_we   = wr_ok && (addr_i == OFS_ACK);
    end

    // control writes with the illegal operation code are dropped
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ctrl_we[c] = wr_ok && (addr_i == ctrl_ofs(c)) &&
                         (wctrl.op != OP_ILLEGAL);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                reload_q[c] <= '0;
                ctrl_q[c]   <= '0;
            end
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_ok && addr_i == reload_ofs(c)) begin
                    reload_q[c] <= bus_wdata[CNT_W-1:0];
                end
                if (ctrl_we[c]) begin
                    ctrl_q[c] <= wctrl;
                end
            end
        end
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            dtu_prescale #(
                .PS_W       (PS_W),
                .TICK_SCALE (TICK_SCALE)
            ) u_ps (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (ctrl_we[ch]),
                .enable  (run_vec[ch]),
                .src     (ctrl_q[ch].src),
                .tick    (tick_vec[ch])
            );

            dtu_chan #(
                .CNT_W (CNT_W)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .ctrl_we (ctrl_we[ch]),
                .op_in   (wctrl.op),
                .reload  (reload_q[ch]),
                .tick    (tick_vec[ch]),
                .count   (cnt_arr[ch]),
                .running (run_vec[ch]),
                .tc      (tc_vec[ch])
            );
        end
    endgenerate

    dtu_intc #(
        .NCH (NUM_CH)
    ) u_intc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tc      (tc_vec),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .status  (status_q),
        .mask    (mask_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else begin
            time_q <= time_q + 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr_i == reload_ofs(c)) bus_rdata = DATA_W'(reload_q[c]);
                if (addr_i == ctrl_ofs(c))   bus_rdata = DATA_W'(ctrl_q[c]);
                if (addr_i == count_ofs(c))  bus_rdata = DATA_W'(cnt_arr[c]);
            end
            if (addr_i == OFS_TIME) bus_rdata = DATA_W'(time_q);
            if (addr_i == OFS_MASK) bus_rdata = DATA_W'(mask_q);
            if (addr_i == OFS_STAT) bus_rdata = DATA_W'(status_q);
        end
    end
endmodule

// File: rtl/dtu_checker.sv
`timescale 1ns/1ps
module dtu_checker #(
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [1:0]        tc,
    input logic [1:0]        status,
    input logic [1:0]        run,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  reload0,
    input logic [TIME_W-1:0] time_q
);
    logic word_wr;
    logic ack_hit;
    logic mask_hit;
    logic ctrl0_hit;

    always_comb begin
        word_wr   = bus_wr && (bus_size == 2'd2);
        ack_hit   = word_wr && (32'(bus_addr) == 32'h4C);
        mask_hit  = word_wr && (32'(bus_addr) == 32'h48);
        ctrl0_hit = word_wr && (32'(bus_addr) == 32'h04);
    end

    // R3
    status0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && !tc[0]) |=> !status[0]);

    // R3
    status1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] && !tc[1]) |=> !status[1]);

    // R8
    status0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(ack_hit && bus_wdata[0])) |=> status[0]);

    // R8
    status1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(ack_hit && bus_wdata[1])) |=> status[1]);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(mask_hit || ack_hit));

    // R5
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !ctrl0_hit) |=> $stable(cnt0));

    // R9
    word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size != 2'd2) |=> $stable(reload0));

    // R11
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (time_q - $past(time_q)) == TIME_W'(1));
endmodule

bind dual_timer_unit dtu_checker #(
    .CNT_W  (CNT_W),
    .TIME_W (TIME_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .tc        (tc_vec),
    .status    (status_q),
    .run       (run_vec),
    .cnt0      (cnt_arr[0]),
    .reload0   (reload_q[0]),
    .time_q    (time_q)
);

// File: tb/dual_timer_unit_bench.sv
`timescale 1ns/1ps
module dual_timer_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_timer_unit u_dual_timer_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    function automatic int a_rel(int ch);  return ch == 0 ? 'h00 : 'h10; endfunction
    function automatic int a_ctl(int ch);  return ch == 0 ? 'h04 : 'h18; endfunction
    function automatic int a_cnt(int ch);  return ch == 0 ? 'h08 : 'h14; endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called just after a falling edge; returns after the next falling edge
    task automatic wr(input int addr, input logic [31:0] data, input logic [1:0] size = 2'd2);
        bus_addr  = 7'(addr);
        bus_wdata = data;
        bus_size  = size;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_size  = 2'd2;
    endtask

    // combinational read inside the low phase; consumes no edge
    task automatic rd(input int addr, output logic [31:0] data, input logic [1:0] size = 2'd2);
        bus_addr = 7'(addr);
        bus_size = size;
        bus_rd   = 1'b1;
        #0.4;
        data     = bus_rdata;
        bus_rd   = 1'b0;
        bus_size = 2'd2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('h50, v); check(v == 0, "R1 status", v, 0);
        rd('h48, v); check(v == 0, "R1 mask", v, 0);
        rd('h08, v); check(v == 0, "R1 count0", v, 0);
        rd('h14, v); check(v == 0, "R1 count1", v, 0);
        rd('h04, v); check(v == 0, "R1 ctrl0", v, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R2 R3 R4 R5 sweep: channel, source code, reload value
        for (int ch = 0; ch < 2; ch++) begin
            for (int code = 5; code < 8; code++) begin
                for (int n = 0; n < 4; n++) begin
                    int r;
                    r = 8 - code;
                    wr(a_ctl(ch), 32'((code << 2) | 1));
                    wr('h4C, 32'h3);
                    wr(a_rel(ch), 32'(n));
                    wr(a_ctl(ch), 32'((code << 2) | 0));
                    rd(a_cnt(ch), v); check(v == n, "R2 load copies reload", v, n);
                    rd(a_rel(ch), v); check(v == n, "R10 reload readback", v, n);
                    wr(a_ctl(ch), 32'((code << 2) | 2));
                    rd(a_ctl(ch), v);
                    check(v == ((code << 2) | 2), "R10 ctrl readback", v, (code << 2) | 2);
                    for (int m = 1; m <= 2 * (n + 1) * r + 1; m++) begin
                        int t;
                        int ec;
                        int es;
                        @(negedge clk);
                        t  = m / r;
                        ec = n - (t % (n + 1));
                        es = (t >= n + 1) ? (1 << ch) : 0;
                        rd(a_cnt(ch), v);
                        check(v == ec, "R3 R4 count", v, ec);
                        rd('h50, v);
                        check(v == es, "R3 R4 status bit", v, es);
                    end
                    wr(a_ctl(ch), 32'((code << 2) | 1));
                    rd(a_cnt(ch), v);
                    repeat (5) @(negedge clk);
                    rd(a_cnt(ch), v2);
                    check(v2 == v, "R5 hold freezes count", v2, v);
                end
            end
        end

        // R7 R8 interrupt masking and acknowledge
        wr('h4C, 32'h3);
        wr('h10, 32'h0);
        wr('h18, 32'((7 << 2) | 0));
        wr('h18, 32'((7 << 2) | 2));
        @(negedge clk);
        wr('h18, 32'((7 << 2) | 1));
        rd('h50, v); check(v == 2, "R3 channel 1 status bit", v, 2);
        wr('h48, 32'h0); check(irq == 0, "R7 masked off", irq, 0);
        wr('h48, 32'h2); check(irq == 1, "R7 mask on", irq, 1);
        rd('h48, v);     check(v == 2, "R10 mask readback", v, 2);
        wr('h48, 32'h1); check(irq == 0, "R7 other bit mask", irq, 0);
        wr('h48, 32'h3); check(irq == 1, "R7 both mask", irq, 1);
        wr('h4C, 32'h1);
        rd('h50, v);     check(v == 2, "R8 zero bit keeps", v, 2);
        check(irq == 1, "R7 irq kept", irq, 1);
        rd('h4C, v);     check(v == 0, "R10 ack reads zero", v, 0);
        wr('h4C, 32'h2);
        rd('h50, v);     check(v == 0, "R8 ack clears", v, 0);
        check(irq == 0, "R7 irq cleared", irq, 0);

        // R8 terminal count wins over a same-cycle acknowledge
        wr('h00, 32'h0);
        wr('h04, 32'((7 << 2) | 0));
        wr('h04, 32'((7 << 2) | 2));
        repeat (3) @(negedge clk);
        wr('h4C, 32'h1);
        rd('h50, v); check(v == 1, "R8 tc beats ack", v, 1);
        wr('h04, 32'((7 << 2) | 1));
        wr('h4C, 32'h1);
        rd('h50, v); check(v == 0, "R8 ack after halt", v, 0);

        // R6 illegal operation code ignored
        wr('h10, 32'd40);
        wr('h18, 32'((7 << 2) | 0));
        wr('h18, 32'((7 << 2) | 2));
        wr('h18, 32'((5 << 2) | 3));
        rd('h18, v); check(v == ((7 << 2) | 2), "R6 ctrl unchanged", v, (7 << 2) | 2);
        rd('h14, v);
        @(negedge clk);
        rd('h14, v2); check(v2 == v - 1, "R6 still running at code 7", v2, v - 1);
        wr('h18, 32'((7 << 2) | 1));

        // R9 word-only access
        wr('h00, 32'h55);
        wr('h00, 32'hAA, 2'd0);
        rd('h00, v); check(v == 32'h55, "R9 byte write ignored", v, 32'h55);
        wr('h00, 32'hBB, 2'd1);
        rd('h00, v); check(v == 32'h55, "R9 half write ignored", v, 32'h55);
        rd('h00, v, 2'd1); check(v == 0, "R9 half read zero", v, 0);
        wr('h48, 32'h0, 2'd0);
        rd('h48, v); check(v == 3, "R9 mask byte write ignored", v, 3);
        rd('h20, v); check(v == 0, "R10 unmapped reads zero", v, 0);

        // R11 time register
        rd('h38, v);
        repeat (10) @(negedge clk);
        rd('h38, v2); check(v2 - v == 10, "R11 time step", v2 - v, 10);
        wr('h38, 32'h0);
        rd('h38, v); check(v - v2 == 1, "R11 time write ignored", v - v2, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule